// File: doc/BRIEF.md
# Serial 1-Wire CRC-8 Checker

This block computes the 8-bit check value that guards 1-Wire device identity codes and scratchpad reads. Bytes arrive one at a time on a valid strobe. Each accepted byte is folded into a running CRC register one bit per clock, least significant bit first. The folding uses a right shift and the reflected polynomial constant 0x8C. This is not the conventional MSB-first CRC-8.

The register begins at zero. Software, or an upstream sequencer, feeds a whole block of bytes, including the CRC byte that the device appended. When every byte has been folded in and the register reads zero, the block arrived intact, and a flag reports that directly. A clear input returns the register to zero and abandons any byte still being shifted, so the next block starts clean.

Top module: `onewire_crc8`

## Requirements
- R1: After reset the CRC output is 0x00, ready is 1 and the zero flag is 1.
- R2: A byte is taken only on a clock edge where in_valid and ready are both high and clr is low. A strobe while ready is low changes neither the CRC result nor the busy time.
- R3: After the edge that accepts a byte, ready is 0 for exactly eight clock cycles. It returns to 1 after the eighth following edge.
- R4: Each data bit is taken LSB first. When (CRC bit 0 XOR data bit) is 1, the CRC becomes (CRC >> 1) XOR 0x8C; otherwise it becomes CRC >> 1.
- R5: The CRC carries over from byte to byte, starting from 0x00, so the value seen when ready returns equals the CRC of all bytes accepted since reset or clear.
- R6: The zero flag is 1 exactly when ready is 1 and the CRC equals 0x00.
- R7: clr high on an edge sets the CRC to 0x00 and ends any byte in progress, so ready is 1 after that edge. clr takes precedence over a simultaneous in_valid.
- R8: Feeding a block followed by its own CRC byte leaves the CRC at 0x00 with the zero flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of CRC and abort of the current byte |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Data byte, bit 0 processed first |
| ready | output | 1 | High when a new byte may be accepted |
| crc | output | 8 | Running CRC register |
| crc_zero | output | 1 | CRC is 0x00 and no byte is in progress |

## Verification
A byte accepted on one edge holds ready low through the next seven falling edges. The final CRC and the return of ready both appear after the eighth edge that follows acceptance. The bench therefore checks ready low one falling edge after acceptance and again seven falling edges later. It compares CRC, ready and zero flag at the eighth falling edge against a bitwise reference function. Clear takes effect on the single edge where it is sampled, so its results are checked at the next falling edge.

// File: rtl/onewire_crc8.sv
module onewire_crc8 #(
  parameter int          DATA_W = 8,
  parameter logic [7:0]  POLY   = 8'h8C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  output logic              ready,
  output logic [7:0]        crc,
  output logic              crc_zero
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sreg;
  logic [CW-1:0]     cnt;
  logic              take;
  logic              fb;

  assign ready    = (cnt == '0);
  assign take     = in_valid && ready && !clr;
  assign fb       = crc[0] ^ sreg[0];
  assign crc_zero = ready && (crc == 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc  <= 8'h00;
      sreg <= '0;
      cnt  <= '0;
    end else if (clr) begin
      crc  <= 8'h00;
      cnt  <= '0;
    end else if (take) begin
      sreg <= in_byte;
      cnt  <= CW'(DATA_W);
    end else if (!ready) begin
      crc  <= (crc >> 1) ^ (fb ? POLY : 8'h00);
      sreg <= sreg >> 1;
      cnt  <= cnt - 1'b1;
    end
  end

  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ready && !clr) |=> !ready);

  p_busy_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !clr) |=> (cnt == $past(cnt) - 1'b1));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !in_valid && !clr) |=> ($stable(crc) && ready));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 8'h00 && ready && crc_zero));

endmodule

// File: tb/test_onewire_crc8.sv
module test_onewire_crc8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       ready;
  logic [7:0] crc;
  logic       crc_zero;

  int errors = 0;
  int checks = 0;
  logic [7:0] model = 8'h00;

  onewire_crc8 i_onewire_crc8 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_byte(in_byte), .ready(ready), .crc(crc), .crc_zero(crc_zero)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] ref_step(logic [7:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if ((c[0] ^ b[0]) == 1'b1) c = (c >> 1) ^ 8'h8C;
      else c = c >> 1;
      b = b >> 1;
    end
    return c;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b, bit poke);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 ready low after accept", {7'd0, ready}, 8'h00);
    model = ref_step(model, b);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (poke && k == 2) begin in_valid = 1'b1; in_byte = ~b; end
      if (poke && k == 5) in_valid = 1'b0;
    end
    check("R3 ready low at seventh edge", {7'd0, ready}, 8'h00);
    @(negedge clk);
    check("R3 ready back after eighth edge", {7'd0, ready}, 8'h01);
    check("R4 R5 crc", crc, model);
    check("R6 zero flag", {7'd0, crc_zero}, {7'd0, model == 8'h00});
  endtask

  task automatic clear_now(logic with_valid);
    @(negedge clk);
    clr = 1'b1;
    in_valid = with_valid;
    @(negedge clk);
    clr = 1'b0;
    in_valid = 1'b0;
    model = 8'h00;
    check("R7 crc cleared", crc, 8'h00);
    check("R7 ready after clear", {7'd0, ready}, 8'h01);
    check("R7 zero flag after clear", {7'd0, crc_zero}, 8'h01);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] blk [8];
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    check("R1 crc at reset", crc, 8'h00);
    check("R1 ready at reset", {7'd0, ready}, 8'h01);
    check("R1 zero flag at reset", {7'd0, crc_zero}, 8'h01);
    rst_n = 1'b1;

    send(8'h00, 1'b0);
    send(8'h01, 1'b0);
    send(8'h80, 1'b0);
    send(8'hFF, 1'b0);
    clear_now(1'b0);

    send(8'hA5, 1'b1);
    send(8'h3C, 1'b1);
    check("R2 strobe while busy ignored", crc, ref_step(ref_step(8'h00, 8'hA5), 8'h3C));

    @(negedge clk);
    in_valid = 1'b1; in_byte = 8'h5A;
    @(negedge clk); @(negedge clk); @(negedge clk);
    clr = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    model = 8'h00;
    check("R7 abort mid byte crc", crc, 8'h00);
    check("R7 abort mid byte ready", {7'd0, ready}, 8'h01);
    repeat (4) @(negedge clk);
    check("R7 abort stays idle", crc, 8'h00);

    clear_now(1'b1);
    repeat (2) @(negedge clk);
    check("R7 clr beats valid", {7'd0, ready}, 8'h01);

    for (int t = 0; t < 6; t++) begin
      logic [7:0] c;
      c = 8'h00;
      clear_now(1'b0);
      for (int j = 0; j < 7; j++) begin
        blk[j] = 8'($urandom);
        c = ref_step(c, blk[j]);
      end
      blk[7] = c;
      for (int j = 0; j < 8; j++) send(blk[j], (j % 3) == 1);
      check("R8 block with crc gives zero", crc, 8'h00);
      check("R8 zero flag", {7'd0, crc_zero}, 8'h01);
    end

    for (int t = 0; t < 20; t++) send(8'($urandom), 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule